// File: doc/BRIEF.md
# Programmable Sum-of-Products Term Array

This block is the logic core of a small programmable logic device with twelve dedicated inputs and ten macrocell feedbacks. Each of the 22 signals is turned into a true and an inverted column, giving 44 columns. A bank of 132 configuration rows decides which columns each product term sees. Each term is the AND of its connected columns. Each output ORs an unequal number of terms, from eight at the edges to sixteen in the middle. One more term per output drives that output's tri-state enable, and two global terms carry the register reset and preset requests to the macrocells.

Configuration is written one row at a time through a synchronous write port. Rows are read back combinationally through a separate read address. A sticky lock makes the array read as fully programmed and freezes every row. Only a full configuration reset clears it. All term outputs are combinational functions of the stored rows and the current inputs.

Top module: `pterm_array`

## Requirements
- R1: Signal k is `dev_in[k]` for k < 12 and `fb_in[k-12]` otherwise; column 2k is its true value and column 2k+1 its complement; a row bit of 0 connects that column to the term, a bit of 1 removes it.
- R2: A term whose row is all ones (no column connected) evaluates to 1.
- R3: A term connected to both the true and the complement column of any one signal evaluates to 0.
- R4: Terms are numbered output by output: for output j the enable term comes first, then its sum terms; the sum-term counts for outputs 0..9 are 8,10,12,14,16,16,14,12,10,8, so output 0 uses terms 0..8 and output 9 ends at term 129; term 130 is the reset term and term 131 the preset term.
- R5: `sum_out[j]` is the OR of exactly the sum terms of output j.
- R6: `oe_out[j]` is the enable term of output j, `rst_term` is term 130 and `pre_term` is term 131.
- R7: A write with `cfg_we` high and `cfg_addr` at most 131 replaces that row at the next rising clock edge; a write to an address above 131 changes nothing.
- R8: While unlocked, `rd_data` shows the row at `rd_addr` combinationally, and reads 0 for an address above 131.
- R9: A `cfg_lock` pulse sets the lock at the next clock edge; the lock then stays set until `rst_n` goes low.
- R10: While locked, `rd_data` is all ones and writes are ignored; a write presented in the same cycle as the lock pulse still takes effect.
- R11: With `rst_n` low every row is cleared to all zeros, so every term is contradictory and reads 0, and the lock is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low configuration reset |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 8 | Row index to write |
| cfg_wdata | input | 44 | Row value, one bit per column |
| cfg_lock | input | 1 | Sets the sticky lock |
| rd_addr | input | 8 | Row index to read |
| rd_data | output | 44 | Row readback, all ones when locked |
| dev_in | input | 12 | Dedicated inputs |
| fb_in | input | 10 | Macrocell feedbacks |
| sum_out | output | 10 | Per-output OR of its sum terms |
| oe_out | output | 10 | Per-output enable term |
| rst_term | output | 1 | Global reset term |
| pre_term | output | 1 | Global preset term |

## Verification
The interesting overlap is a row write arriving in the same cycle as the lock pulse. The bench drives both together and then expects the written row to be live in the term outputs, while readback is already masked. It next drives a different write to the same row and changes the inputs so that the two rows would produce different outputs. It then confirms that the outputs still follow the first row. A behavioural model of the rows and the lock is compared with every output on each clock, so any ordering error between the write and the lock shows up at once.

// File: rtl/pterm_array.sv
module pterm_array #(
  parameter int N_IN    = 12,
  parameter int N_OUT   = 10,
  parameter int MIN_SUM = 8,
  localparam int NSIG   = N_IN + N_OUT,
  localparam int NCOL   = 2 * NSIG,
  localparam int NTERMS = N_OUT * MIN_SUM + N_OUT * (N_OUT / 2 - 1) + N_OUT + 2,
  localparam int AW     = $clog2(NTERMS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [NCOL-1:0] cfg_wdata,
  input  logic            cfg_lock,
  input  logic [AW-1:0]   rd_addr,
  output logic [NCOL-1:0] rd_data,
  input  logic [N_IN-1:0] dev_in,
  input  logic [N_OUT-1:0] fb_in,
  output logic [N_OUT-1:0] sum_out,
  output logic [N_OUT-1:0] oe_out,
  output logic            rst_term,
  output logic            pre_term
);

  localparam logic [AW-1:0] LAST = AW'(NTERMS - 1);

  function automatic int sum_cnt(int j);
    return (j < N_OUT / 2) ? MIN_SUM + 2 * j : MIN_SUM + 2 * (N_OUT - 1 - j);
  endfunction

  function automatic int base_of(int j);
    int b = 0;
    for (int i = 0; i < j; i++) b += sum_cnt(i) + 1;
    return b;
  endfunction

  logic [NTERMS-1:0][NCOL-1:0] fuse;
  logic                        lock_q;
  logic [NSIG-1:0]             sig;
  logic [NCOL-1:0]             col;
  logic [NTERMS-1:0]           term;

  assign sig = {fb_in, dev_in};

  for (genvar k = 0; k < NSIG; k++) begin : g_col
    assign col[2*k]   = sig[k];
    assign col[2*k+1] = ~sig[k];
  end

  for (genvar t = 0; t < NTERMS; t++) begin : g_term
    assign term[t] = &(fuse[t] | col);
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    localparam int B = base_of(j);
    localparam int C = sum_cnt(j);
    assign oe_out[j]  = term[B];
    assign sum_out[j] = |term[B+C:B+1];
  end

  assign rst_term = term[NTERMS-2];
  assign pre_term = term[NTERMS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse   <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cfg_we && !lock_q && cfg_addr <= LAST) fuse[cfg_addr] <= cfg_wdata;
      if (cfg_lock) lock_q <= 1'b1;
    end
  end

  always_comb begin
    if (lock_q)               rd_data = '1;
    else if (rd_addr <= LAST) rd_data = fuse[rd_addr];
    else                      rd_data = '0;
  end

  // R3: a term that sees both polarities of one signal can never be high
  always_comb begin
    for (int t = 0; t < NTERMS; t++)
      for (int k = 0; k < NSIG; k++)
        if (!fuse[t][2*k] && !fuse[t][2*k+1])
          a_r3_contradiction_low: assert (!term[t]);
  end

  a_r9_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> lock_q);

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !lock_q && cfg_addr <= LAST) |=> fuse[$past(cfg_addr)] == $past(cfg_wdata));

  a_r10_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(fuse));

endmodule

// File: tb/pterm_array_tb.sv
module pterm_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [43:0] cfg_wdata = '0;
  logic        cfg_lock = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [43:0] rd_data;
  logic [11:0] dev_in = '0;
  logic [9:0]  fb_in = '0;
  logic [9:0]  sum_out, oe_out;
  logic        rst_term, pre_term;

  int total = 0;
  int bad = 0;
  logic [43:0] m [0:131];
  bit lk;
  int en_idx [10];
  int s_cnt  [10];

  always #10 clk = ~clk;

  pterm_array dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_lock(cfg_lock), .rd_addr(rd_addr),
    .rd_data(rd_data), .dev_in(dev_in), .fb_in(fb_in), .sum_out(sum_out),
    .oe_out(oe_out), .rst_term(rst_term), .pre_term(pre_term)
  );

  // R1, R2, R3: behavioural term evaluation
  function automatic bit tval(int t);
    bit r = 1'b1;
    bit v;
    for (int k = 0; k < 22; k++) begin
      v = (k < 12) ? dev_in[k] : fb_in[k-12];
      if (!m[t][2*k]   && !v) r = 1'b0;
      if (!m[t][2*k+1] &&  v) r = 1'b0;
    end
    return r;
  endfunction

  task automatic check();
    logic [9:0]  es, eo;
    logic [43:0] er;
    for (int j = 0; j < 10; j++) begin
      es[j] = 1'b0;
      for (int s = 0; s < s_cnt[j]; s++) es[j] = es[j] | tval(en_idx[j] + 1 + s);
      eo[j] = tval(en_idx[j]);
    end
    er = lk ? '1 : (rd_addr <= 131 ? m[rd_addr] : '0);
    total += 5;
    if (sum_out !== es) begin bad++; $display("FAIL R5 sum_out act=%h exp=%h", sum_out, es); end
    if (oe_out !== eo) begin bad++; $display("FAIL R6 oe_out act=%h exp=%h", oe_out, eo); end
    if (rst_term !== tval(130)) begin bad++; $display("FAIL R6 rst_term act=%b exp=%b", rst_term, tval(130)); end
    if (pre_term !== tval(131)) begin bad++; $display("FAIL R6 pre_term act=%b exp=%b", pre_term, tval(131)); end
    if (rd_data !== er) begin bad++; $display("FAIL R8/R10 rd_data act=%h exp=%h", rd_data, er); end
  endtask

  // R7, R9: model update at the clock edge, compare on the falling edge
  task automatic step();
    @(posedge clk);
    if (cfg_we && !lk && cfg_addr <= 131) m[cfg_addr] = cfg_wdata;
    if (cfg_lock) lk = 1'b1;
    @(negedge clk);
    check();
  endtask

  task automatic wr(int a, logic [43:0] d);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  // R11
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int t = 0; t < 132; t++) m[t] = '0;
    lk = 1'b0;
    #1;
    check();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [43:0] conn(int c);
    logic [43:0] r = '1;
    r[c] = 1'b0;
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b = 0;
    // R4: index layout
    for (int j = 0; j < 10; j++) begin
      s_cnt[j]  = (j < 5) ? 8 + 2 * j : 8 + 2 * (9 - j);
      en_idx[j] = b;
      b += s_cnt[j] + 1;
    end
    for (int t = 0; t < 132; t++) m[t] = '0;
    lk = 1'b0;
    do_reset();
    step();

    // R1: true column of dev_in[0] on first sum term of output 0
    wr(1, conn(0));
    dev_in = 12'h001; step();
    dev_in = 12'h000; step();
    // R1: complement column of dev_in[1] on a later sum term
    wr(2, conn(3));
    dev_in = 12'h002; step();
    // R1: feedback columns on enable term of output 9
    wr(en_idx[9], conn(2*21) & conn(2*11+1));
    fb_in = 10'h200; dev_in = 12'h000; step();
    dev_in = 12'h800; step();
    // R2: empty reset term
    wr(130, '1);
    step();
    // R3: contradictory preset term
    wr(131, conn(4) & conn(5));
    dev_in = 12'h004; step();
    dev_in = 12'h000; step();
    // R4: boundary terms of outputs 4 and 5
    wr(en_idx[4] + 16, '1);
    wr(en_idx[5] + 1, conn(6));
    wr(en_idx[4] + 16, conn(6) & conn(7));
    dev_in = 12'h008; step();
    // R7, R8: out-of-range write and read
    wr(200, '1);
    rd_addr = 8'd200; step();
    rd_addr = 8'd131; step();

    // random rows and inputs
    for (int t = 0; t < 132; t++) begin
      logic [43:0] r = '1;
      int n = $urandom_range(0, 3);
      for (int i = 0; i < n; i++) r[$urandom_range(0, 43)] = 1'b0;
      wr(t, r);
    end
    for (int i = 0; i < 300; i++) begin
      dev_in = 12'($urandom); fb_in = 10'($urandom);
      rd_addr = 8'($urandom_range(0, 140));
      step();
    end

    // R10: write in the lock cycle lands, later write ignored
    dev_in = 12'h000; fb_in = 10'h000;
    cfg_lock = 1'b1;
    wr(1, conn(0));
    cfg_lock = 1'b0;
    rd_addr = 8'd1; step();
    wr(1, conn(1));
    dev_in = 12'h001; step();
    dev_in = 12'h000; step();
    // R9: lock persists
    for (int i = 0; i < 5; i++) step();
    // R11: reset clears lock and rows
    do_reset();
    rd_addr = 8'd1; step();
    wr(1, conn(1));
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule